// File: doc/BRIEF.md
# Eight-Pin Bidirectional Port with Peripheral Takeover and Wakeup Capture

This block controls eight bidirectional pads. For each pin, software holds a drive bit and a direction bit. Together these two bits set the pin to one of three states: floating input, input with a weak pull-up, or push-pull output. Software can also hand any pin to a peripheral. While a pin is handed over, its stored direction and drive bits no longer reach the pad, but they keep their values. On pins 0 to 3 the peripheral is a serial peripheral interface. Pin 0 is MISO, pin 1 is MOSI, pin 2 is SCK and pin 3 is slave-select. The direction of each of these pins follows the interface's master or slave role. On pins 4 to 7, the peripheral supplies the output enable and output value directly.

Every pad input passes through a two-flop synchronizer. The synchronized level can be read by software and is also given to the peripherals. The same levels feed a wakeup detector. Each pin has an enable bit and an edge-select bit, and a selected edge on an enabled pin sets a sticky pending bit. Software clears a pending bit by writing 1 to it. When pin 7 is handed over, its wakeup source becomes a receive-activity signal from a peripheral instead of the pad level. The pad level of pin 7 stays readable.

The register bus is a single-cycle write port with a combinational read. The pad-facing outputs are combinational functions of the registers and the peripheral inputs.

Top module: `gpio_alt_port`

## Requirements
- R1: After reset, every register reads 0 and every pin is a floating input: pad_oe, pad_o and pad_pu are all 0.
- R2: For a pin that is not handed over, the direction bit and drive bit select the pad state. With direction 1, pad_oe=1, pad_o equals the drive bit and pad_pu=0. With direction 0 and drive 1, the pin pulls up: pad_pu=1, pad_oe=0, pad_o=0. With direction 0 and drive 0, the pin floats: all three outputs are 0. pad_pu and pad_oe are never both 1.
- R3: The register addresses are: 0 drive, 1 direction, 2 takeover select, 3 wakeup enable, 4 edge select, 5 wakeup pending, 6 synchronized pin level (read only). Address 7 reads 0. Registers at addresses 0 to 4 read back the last value written to them.
- R4: While takeover bit i is set for a pin i from 4 to 7, pad_oe[i]=per_oe[i], pad_o[i]=per_o[i] and pad_pu[i]=0, whatever the drive and direction bits hold. Those two bits keep their values and still read back.
- R5: While spi_en=1 and the takeover bit of a pin from 0 to 3 is set, that pin's direction follows the role. With spi_master=1, pins 1, 2 and 3 drive and pin 0 listens. With spi_master=0, only pin 0 drives. A driving pin outputs per_o[i]. No pull-up is applied to these pins.
- R6: While spi_en=0, pins 0 to 3 behave as in R2 even if their takeover bits are set.
- R7: A pad level change appears at address 6 and on pin_level after exactly two rising clock edges, not after one.
- R8: For a wakeup-enabled pin, edge-select 0 captures a rising edge of the synchronized source and edge-select 1 captures a falling edge. The edge sets that pin's pending bit, which stays set. wake_irq is 1 whenever any pending bit is set.
- R9: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. If an edge is captured in the same cycle as a clear, the bit stays set.
- R10: While takeover bit 7 is set, wakeup bit 7 is taken from rx_act instead of pad 7, and the level of pad 7 still reads at address 6.
- R11: Edges on pins whose wakeup enable is 0 never set a pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| pad_in | input | 8 | Pad input levels |
| pad_oe | output | 8 | Pad output enable |
| pad_o | output | 8 | Pad output value |
| pad_pu | output | 8 | Pad weak pull-up enable |
| per_oe | input | 8 | Peripheral output enable (pins 4 to 7) |
| per_o | input | 8 | Peripheral output value |
| spi_en | input | 1 | Serial interface enabled |
| spi_master | input | 1 | Serial interface is master |
| rx_act | input | 1 | Receive-activity wakeup source for pin 7 |
| pin_level | output | 8 | Synchronized pad levels |
| wake_irq | output | 1 | Any wakeup pending |

## Verification
Some properties are checked by assertions on every cycle. These are: pull-up and output enable are never both active, the serial pin directions match the master or slave role, handed-over pins 4 to 7 follow the peripheral, a pending bit rises only on an enabled pin, and a pending bit falls only after a write to the pending register. Other behaviour is shown only by the bench's scenarios. This covers the two-edge synchronizer latency, the edge polarity choice, the set-over-clear priority, the substitution of rx_act for pad 7, and the fact that stored direction and drive bits survive a takeover.

// File: rtl/gpio_alt_pkg.sv
package gpio_alt_pkg;
    typedef enum logic [2:0] {
        RA_DRIVE = 3'd0,
        RA_DIR   = 3'd1,
        RA_ALT   = 3'd2,
        RA_WEN   = 3'd3,
        RA_EDGE  = 3'd4,
        RA_PEND  = 3'd5,
        RA_LEVEL = 3'd6,
        RA_NONE  = 3'd7
    } reg_addr_e;

    typedef enum logic [2:0] {
        PM_FLOAT,
        PM_PULL,
        PM_DRIVE,
        PM_ALT_DRIVE,
        PM_ALT_LISTEN
    } pin_mode_e;

    localparam int SPI_PINS = 4;
endpackage

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
    import gpio_alt_pkg::*;
#(
    parameter bit IS_SPI       = 1'b0,
    parameter bit MASTER_DRIVE = 1'b0
) (
    input  logic drive_bit,
    input  logic dir_bit,
    input  logic alt_bit,
    input  logic spi_en,
    input  logic spi_master,
    input  logic per_oe,
    input  logic per_o,
    output logic oe,
    output logic o,
    output logic pu
);
    logic      alt_live;
    logic      alt_wants_drive;
    pin_mode_e mode;

    always_comb begin
        if (IS_SPI) begin
            alt_live        = alt_bit & spi_en;
            alt_wants_drive = (spi_master == MASTER_DRIVE);
        end else begin
            alt_live        = alt_bit;
            alt_wants_drive = per_oe;
        end
    end

    always_comb begin
        if (alt_live)
            mode = alt_wants_drive ? PM_ALT_DRIVE : PM_ALT_LISTEN;
        else if (dir_bit)
            mode = PM_DRIVE;
        else if (drive_bit)
            mode = PM_PULL;
        else
            mode = PM_FLOAT;
    end

    always_comb begin
        oe = 1'b0;
        o  = 1'b0;
        pu = 1'b0;
        unique case (mode)
            PM_FLOAT:      ;
            PM_PULL:       pu = 1'b1;
            PM_DRIVE:      begin oe = 1'b1; o = drive_bit; end
            PM_ALT_DRIVE:  begin oe = 1'b1; o = per_o; end
            PM_ALT_LISTEN: ;
            default:       ;
        endcase
    end
endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_wake.sv
module gpio_wake #(
    parameter int W       = 8,
    parameter int ALT_PIN = W - 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    input  logic         alt_src_sel,
    input  logic         rx_act,
    input  logic [W-1:0] en,
    input  logic [W-1:0] edge_sel,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] pend
);
    logic [W-1:0] src;
    logic [W-1:0] prev_q;
    logic [W-1:0] hit;

    always_comb begin
        src = level;
        if (alt_src_sel)
            src[ALT_PIN] = rx_act;
    end

    for (genvar i = 0; i < W; i++) begin : g_edge
        assign hit[i] = en[i] & (edge_sel[i] ? (prev_q[i] & ~src[i])
                                             : (~prev_q[i] & src[i]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            pend   <= '0;
        end else begin
            prev_q <= src;
            pend   <= (pend & ~clr_mask) | hit;
        end
    end
endmodule

// File: rtl/gpio_alt_port.sv
module gpio_alt_port
    import gpio_alt_pkg::*;
#(
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [N_PINS-1:0] wdata,
    output logic [N_PINS-1:0] rdata,
    input  logic [N_PINS-1:0] pad_in,
    output logic [N_PINS-1:0] pad_oe,
    output logic [N_PINS-1:0] pad_o,
    output logic [N_PINS-1:0] pad_pu,
    input  logic [N_PINS-1:0] per_oe,
    input  logic [N_PINS-1:0] per_o,
    input  logic              spi_en,
    input  logic              spi_master,
    input  logic              rx_act,
    output logic [N_PINS-1:0] pin_level,
    output logic              wake_irq
);
    localparam int WAKE_ALT_PIN = N_PINS - 1;

    logic [N_PINS-1:0] drive_q, dir_q, alt_q, wen_q, edge_q;
    logic [N_PINS-1:0] pend_q;
    logic [N_PINS-1:0] clr_mask;
    reg_addr_e         ra;

    assign ra = reg_addr_e'(addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive_q <= '0;
            dir_q   <= '0;
            alt_q   <= '0;
            wen_q   <= '0;
            edge_q  <= '0;
        end else if (wr_en) begin
            unique case (ra)
                RA_DRIVE: drive_q <= wdata;
                RA_DIR:   dir_q   <= wdata;
                RA_ALT:   alt_q   <= wdata;
                RA_WEN:   wen_q   <= wdata;
                RA_EDGE:  edge_q  <= wdata;
                default:  ;
            endcase
        end
    end

    assign clr_mask = (wr_en && ra == RA_PEND) ? wdata : '0;

    always_comb begin
        rdata = '0;
        unique case (ra)
            RA_DRIVE: rdata = drive_q;
            RA_DIR:   rdata = dir_q;
            RA_ALT:   rdata = alt_q;
            RA_WEN:   rdata = wen_q;
            RA_EDGE:  rdata = edge_q;
            RA_PEND:  rdata = pend_q;
            RA_LEVEL: rdata = pin_level;
            RA_NONE:  rdata = '0;
            default:  rdata = '0;
        endcase
    end

    gpio_sync2 #(.W(N_PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pin_level)
    );

    gpio_wake #(.W(N_PINS), .ALT_PIN(WAKE_ALT_PIN)) u_wake (
        .clk         (clk),
        .rst_n       (rst_n),
        .level       (pin_level),
        .alt_src_sel (alt_q[WAKE_ALT_PIN]),
        .rx_act      (rx_act),
        .en          (wen_q),
        .edge_sel    (edge_q),
        .clr_mask    (clr_mask),
        .pend        (pend_q)
    );

    assign wake_irq = |pend_q;

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        gpio_pin_ctrl #(
            .IS_SPI       (i < SPI_PINS),
            .MASTER_DRIVE (i != 0)
        ) u_pin (
            .drive_bit  (drive_q[i]),
            .dir_bit    (dir_q[i]),
            .alt_bit    (alt_q[i]),
            .spi_en     (spi_en),
            .spi_master (spi_master),
            .per_oe     (per_oe[i]),
            .per_o      (per_o[i]),
            .oe         (pad_oe[i]),
            .o          (pad_o[i]),
            .pu         (pad_pu[i])
        );
    end
endmodule

// File: rtl/gpio_alt_port_chk.sv
module gpio_alt_port_chk #(
    parameter int N_PINS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [2:0]        addr,
    input logic [N_PINS-1:0] pad_oe,
    input logic [N_PINS-1:0] pad_pu,
    input logic [N_PINS-1:0] per_oe,
    input logic              spi_en,
    input logic              spi_master,
    input logic [N_PINS-1:0] alt_q,
    input logic [N_PINS-1:0] wen_q,
    input logic [N_PINS-1:0] pend_q
);
    localparam logic [N_PINS-1:0] HI_MASK = {{(N_PINS-4){1'b1}}, 4'b0000};

    AST_PU_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_oe) == '0);  // R2

    AST_SPI_MASTER_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_en && spi_master && alt_q[3:0] == 4'hF) |-> (pad_oe[3:0] == 4'b1110));  // R5

    AST_SPI_SLAVE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_en && !spi_master && alt_q[3:0] == 4'hF) |-> (pad_oe[3:0] == 4'b0001));  // R5

    AST_ALT_FOLLOWS_PER: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & alt_q & HI_MASK) == (per_oe & alt_q & HI_MASK));  // R4

    AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q & ~$past(pend_q) & ~$past(wen_q)) == '0);  // R11

    AST_PEND_CLR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ((~pend_q & $past(pend_q)) != '0) |-> $past(wr_en && addr == 3'd5));  // R9
endmodule

bind gpio_alt_port gpio_alt_port_chk #(.N_PINS(N_PINS)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .pad_oe     (pad_oe),
    .pad_pu     (pad_pu),
    .per_oe     (per_oe),
    .spi_en     (spi_en),
    .spi_master (spi_master),
    .alt_q      (alt_q),
    .wen_q      (wen_q),
    .pend_q     (pend_q)
);

// File: tb/gpio_alt_port_tb_top.sv
module gpio_alt_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_oe, pad_o, pad_pu;
    logic [7:0] per_oe = '0;
    logic [7:0] per_o = '0;
    logic       spi_en = 1'b0;
    logic       spi_master = 1'b0;
    logic       rx_act = 1'b0;
    logic [7:0] pin_level;
    logic       wake_irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_alt_port dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pad_in(pad_in), .pad_oe(pad_oe), .pad_o(pad_o),
        .pad_pu(pad_pu), .per_oe(per_oe), .per_o(per_o), .spi_en(spi_en),
        .spi_master(spi_master), .rx_act(rx_act), .pin_level(pin_level),
        .wake_irq(wake_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    // Expected pad outputs {oe, o, pu} from the requirements R2, R4, R5, R6
    function automatic logic [23:0] exp_pads(
        input logic [7:0] drv, input logic [7:0] dir, input logic [7:0] alt,
        input logic sen, input logic mst, input logic [7:0] poe, input logic [7:0] po);
        logic [7:0] oe, o, pu;
        for (int i = 0; i < 8; i++) begin
            logic live, drive;
            live  = alt[i] && (i >= 4 || sen);
            drive = (i >= 4) ? poe[i] : (mst ? (i != 0) : (i == 0));
            oe[i] = 1'b0; o[i] = 1'b0; pu[i] = 1'b0;
            if (live) begin
                if (drive) begin oe[i] = 1'b1; o[i] = po[i]; end
            end else if (dir[i]) begin
                oe[i] = 1'b1; o[i] = drv[i];
            end else if (drv[i]) begin
                pu[i] = 1'b1;
            end
        end
        return {oe, o, pu};
    endfunction

    task automatic report;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            report();
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'h0000_5eed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pads", {pad_oe, pad_o, pad_pu}, 24'h0);
        for (int a = 0; a < 8; a++) begin
            rd(a[2:0], v);
            check("R1 regs", v, 8'h00);
        end

        // R2 directed mode table
        wr(3'd0, 8'b0000_0101);
        wr(3'd1, 8'b0000_0011);
        check("R2 table", {pad_oe, pad_o, pad_pu}, {8'h03, 8'h01, 8'h04});

        // R3 readback of writable registers and reserved address
        wr(3'd3, 8'h00); wr(3'd4, 8'h5A);
        rd(3'd4, v); check("R3 edge rb", v, 8'h5A);
        rd(3'd7, v); check("R3 addr7", v, 8'h00);
        wr(3'd4, 8'h00);

        // R2 R4 R5 R6 random mix
        for (int k = 0; k < 40; k++) begin
            logic [7:0] d, c, al;
            d = 8'($urandom); c = 8'($urandom); al = 8'($urandom);
            if (k == 0) al = 8'hFF;
            wr(3'd0, d); wr(3'd1, c); wr(3'd2, al);
            @(negedge clk);
            spi_en = 1'($urandom); spi_master = 1'($urandom);
            per_oe = 8'($urandom); per_o = 8'($urandom);
            #1;
            check("R4/R5/R6 pads", {pad_oe, pad_o, pad_pu},
                  exp_pads(d, c, al, spi_en, spi_master, per_oe, per_o));
            rd(3'd0, v); check("R4 drive kept", v, d);
            rd(3'd1, v); check("R4 dir kept", v, c);
        end
        // R5 directed: master and slave with all serial pins taken
        wr(3'd2, 8'h0F); wr(3'd1, 8'h00); wr(3'd0, 8'h00);
        @(negedge clk); spi_en = 1'b1; spi_master = 1'b1; per_o = 8'hFF; #1;
        check("R5 master", {pad_oe[3:0], pad_o[3:0], pad_pu[3:0]}, 12'hEE0);
        spi_master = 1'b0; #1;
        check("R5 slave", {pad_oe[3:0], pad_o[3:0], pad_pu[3:0]}, 12'h110);
        wr(3'd0, 8'h0F); spi_en = 1'b0; #1;
        check("R6 spi off", {pad_oe[3:0], pad_pu[3:0]}, 8'h0F);
        wr(3'd2, 8'h00); wr(3'd0, 8'h00); per_oe = '0; per_o = '0;

        // R7 synchronizer latency
        @(negedge clk); pad_in = 8'hA5;
        @(negedge clk); rd(3'd6, v); check("R7 after one edge", v, 8'h00);
        @(negedge clk); rd(3'd6, v); check("R7 after two edges", v, 8'hA5);
        check("R7 pin_level", pin_level, 8'hA5);
        @(negedge clk); pad_in = 8'h00;
        repeat (4) @(negedge clk);

        // R11 disabled pin edges ignored
        pad_in = 8'h02; repeat (4) @(negedge clk);
        rd(3'd5, v); check("R11 no pend", v, 8'h00);
        pad_in = 8'h00; repeat (4) @(negedge clk);

        // R8 rising on pin 1, falling on pin 2
        wr(3'd4, 8'h04); wr(3'd3, 8'h06);
        pad_in = 8'h04; repeat (4) @(negedge clk);
        rd(3'd5, v); check("R8 fall not yet", v, 8'h00);
        pad_in = 8'h02; repeat (4) @(negedge clk);
        rd(3'd5, v); check("R8 rise+fall", v, 8'h06);
        pad_in = 8'h00; repeat (4) @(negedge clk);
        rd(3'd5, v); check("R8 sticky", v, 8'h06);
        check("R8 irq", wake_irq, 1'b1);

        // R9 write-one-to-clear
        wr(3'd5, 8'h02);
        rd(3'd5, v); check("R9 partial clear", v, 8'h04);
        wr(3'd5, 8'h04);
        check("R9 irq low", wake_irq, 1'b0);

        // R10 pin 7 wakeup from rx_act; pad still readable
        wr(3'd3, 8'h00); wr(3'd4, 8'h00);
        wr(3'd2, 8'h80); wr(3'd3, 8'h80);
        pad_in = 8'h80; repeat (4) @(negedge clk);
        rd(3'd5, v); check("R10 pad ignored", v, 8'h00);
        rd(3'd6, v); check("R10 level readable", v, 8'h80);
        rx_act = 1'b1; repeat (2) @(negedge clk);
        rd(3'd5, v); check("R10 rx_act edge", v, 8'h80);
        rx_act = 1'b0; @(negedge clk);
        wr(3'd5, 8'h80);

        // R9 set wins over same-cycle clear
        @(negedge clk);
        rx_act = 1'b1; wr_en = 1'b1; addr = 3'd5; wdata = 8'h80;
        @(negedge clk);
        wr_en = 1'b0;
        rd(3'd5, v); check("R9 set beats clear", v, 8'h80);

        done = 1'b1;
        report();
    end
endmodule